// File: doc/BRIEF.md
# Interlace Mode Sync Switch Controller

This block sits beside a video sync generator. It decides which field is in progress and tells the generator whether the falling edges of horizontal and vertical sync line up or sit half a line apart. It also owns the choice between interlaced and progressive (noninterlaced) timing. A mode request from the control side is not applied at once. It waits in a pending register until a safe field boundary, so that the sync sequence seen downstream is never cut in the middle of a field pair.

Field boundaries come from one of two sources, chosen by a master/slave select. In master mode a boundary is the cycle in which the incoming line index wraps from a nonzero value to zero. In slave mode a boundary is a falling edge of the external active-low vertical sync. In interlaced timing the block alternates between field 1 and field 2. In progressive timing every field is field 1 with coincident sync edges, and the field output then serves only as an optional parity indicator.

The controller is a four-state machine. The states are INT_F1 (interlaced, field 1), INT_F2 (interlaced, field 2), NI_EVEN and NI_ODD (progressive, even and odd field parity). On a boundary with no mode change applied, the state moves INT_F1→INT_F2, INT_F2→INT_F1, NI_EVEN→NI_ODD and NI_ODD→NI_EVEN. When a boundary applies a pending change, the state jumps to NI_EVEN if the new mode is progressive, or to INT_F1 if the new mode is interlaced.

Top module: `ilace_switch`

## Requirements
- R1: Reset (rst_n low, asynchronous) gives state INT_F1 with no request pending. The outputs are then mode_nonint=0, field_o=0, sync_coinc=1 and mode_chg=0.
- R2: In interlaced timing with no change applied, each field boundary swaps field 1 and field 2. field_o is 1 in field 2 and 0 in field 1.
- R3: sync_coinc is 0 (vertical sync half a line from horizontal sync) only in interlaced field 2. It is 1 in every other state, including all progressive fields.
- R4: In progressive timing, field_o is held at 0 while field_en is 0. While field_en is 1, field_o shows field parity: it is 0 in NI_EVEN and 1 in NI_ODD, and the parity flips at each boundary.
- R5: With master_sel=1, a boundary is the cycle where line_idx is 0 and was nonzero in the previous cycle. With master_sel=0, a boundary is the cycle where vsync_n is 0 and was 1 in the previous cycle. The source that is not selected has no effect, and holding vsync_n low makes no further boundaries.
- R6: In master mode a pending change is applied only at a boundary that starts field 1, that is, from INT_F2, NI_EVEN or NI_ODD. A boundary reached from INT_F1 leaves the request pending.
- R7: In slave mode a pending change is applied at the first falling vsync_n in a cycle after the request cycle, from any state. A request strobed in the same cycle as a falling edge waits for the next edge.
- R8: A request (req_stb=1 with req_nonint, where 1 means progressive) overwrites any earlier pending request. When the pending value equals the active mode, the boundary consumes it and the mode does not change.
- R9: mode_chg is a one-clock pulse in the first cycle that shows the new mode_nonint value. It is 0 in every cycle where mode_nonint keeps its value.
- R10: After a mode change the new mode starts in field 1 (INT_F1 or NI_EVEN), so field_o is 0 in the pulse cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_stb | input | 1 | One-cycle strobe carrying a mode request |
| req_nonint | input | 1 | Requested mode: 1 progressive, 0 interlaced |
| master_sel | input | 1 | 1 master (line index boundaries), 0 slave (external vertical sync) |
| field_en | input | 1 | Enables the parity indication on field_o in progressive timing |
| line_idx | input | LINE_W | Line index within the field from the line counter |
| vsync_n | input | 1 | External vertical sync, active low, used in slave mode |
| mode_nonint | output | 1 | Active mode: 1 progressive, 0 interlaced |
| field_o | output | 1 | Field indicator |
| sync_coinc | output | 1 | 1 when horizontal and vertical sync falling edges coincide |
| mode_chg | output | 1 | One-clock pulse when the active mode changes |

## Verification
The bench builds the block with LINE_W set to 6 in place of the default 10. The line index only feeds a zero test and a nonzero test, so a narrow width reaches every case, and the bench produces boundaries by moving between line 5 and line 0. Both boundary sources run in one sequence, and master_sel is switched partway through. This covers the master rule that blocks a change out of field 1, the slave rule that accepts a change from any field, a request that lands in the same cycle as a falling vsync_n, a request that replaces an earlier one, and a request for the mode already active. A reset applied while a request is pending shows that the request is discarded.

// File: rtl/ilace_pkg.sv
package ilace_pkg;

    typedef enum logic [1:0] {
        ST_INT_F1  = 2'd0,
        ST_INT_F2  = 2'd1,
        ST_NI_EVEN = 2'd2,
        ST_NI_ODD  = 2'd3
    } ilace_state_e;

endpackage

// File: rtl/ilace_evt.sv
module ilace_evt #(
    parameter int LINE_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              master_sel,
    input  logic [LINE_W-1:0] line_idx,
    input  logic              vsync_n,
    output logic              fs_evt
);
    localparam logic [LINE_W-1:0] LINE_ZERO = '0;

    logic line_nz_q;
    logic vs_q;
    logic wrap_evt;
    logic fall_evt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_nz_q <= 1'b0;
            vs_q      <= 1'b1;
        end else begin
            line_nz_q <= (line_idx != LINE_ZERO);
            vs_q      <= vsync_n;
        end
    end

    // line counter wrap marks a field start in master mode
    assign wrap_evt = (line_idx == LINE_ZERO) && line_nz_q;
    // falling edge of external vertical sync in slave mode
    assign fall_evt = vs_q && !vsync_n;

    assign fs_evt = master_sel ? wrap_evt : fall_evt;

endmodule

// File: rtl/ilace_pend.sv
module ilace_pend (
    input  logic clk,
    input  logic rst_n,
    input  logic req_stb,
    input  logic req_nonint,
    input  logic take,
    output logic pend_vld,
    output logic pend_nonint
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_vld    <= 1'b0;
            pend_nonint <= 1'b0;
        end else if (req_stb) begin
            // a fresh request always wins and stays for the next boundary
            pend_vld    <= 1'b1;
            pend_nonint <= req_nonint;
        end else if (take) begin
            pend_vld    <= 1'b0;
        end
    end

endmodule

// File: rtl/ilace_fsm.sv
module ilace_fsm
    import ilace_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fs_evt,
    input  logic master_sel,
    input  logic field_en,
    input  logic pend_vld,
    input  logic pend_nonint,
    output logic take,
    output logic mode_nonint,
    output logic field_o,
    output logic sync_coinc,
    output logic mode_chg
);
    ilace_state_e state_q;
    ilace_state_e state_d;
    logic         cur_ni;
    logic         safe_pt;
    logic         do_chg;
    logic         chg_q;

    assign cur_ni  = (state_q == ST_NI_EVEN) || (state_q == ST_NI_ODD);
    // master: only a boundary that opens field 1; slave: any boundary
    assign safe_pt = !master_sel || (state_q != ST_INT_F1);
    assign take    = pend_vld && fs_evt && safe_pt;
    assign do_chg  = take && (pend_nonint != cur_ni);

    always_comb begin
        state_d = state_q;
        if (do_chg) begin
            state_d = pend_nonint ? ST_NI_EVEN : ST_INT_F1;
        end else if (fs_evt) begin
            unique case (state_q)
                ST_INT_F1:  state_d = ST_INT_F2;
                ST_INT_F2:  state_d = ST_INT_F1;
                ST_NI_EVEN: state_d = ST_NI_ODD;
                ST_NI_ODD:  state_d = ST_NI_EVEN;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_INT_F1;
            chg_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            chg_q   <= do_chg;
        end
    end

    always_comb begin
        mode_nonint = 1'b0;
        field_o     = 1'b0;
        sync_coinc  = 1'b1;
        unique case (state_q)
            ST_INT_F1: begin
                mode_nonint = 1'b0;
                field_o     = 1'b0;
                sync_coinc  = 1'b1;
            end
            ST_INT_F2: begin
                mode_nonint = 1'b0;
                field_o     = 1'b1;
                sync_coinc  = 1'b0;
            end
            ST_NI_EVEN: begin
                mode_nonint = 1'b1;
                field_o     = 1'b0;
                sync_coinc  = 1'b1;
            end
            ST_NI_ODD: begin
                mode_nonint = 1'b1;
                field_o     = field_en;
                sync_coinc  = 1'b1;
            end
        endcase
    end

    assign mode_chg = chg_q;

endmodule

// File: rtl/ilace_switch.sv
module ilace_switch #(
    parameter int LINE_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_stb,
    input  logic              req_nonint,
    input  logic              master_sel,
    input  logic              field_en,
    input  logic [LINE_W-1:0] line_idx,
    input  logic              vsync_n,
    output logic              mode_nonint,
    output logic              field_o,
    output logic              sync_coinc,
    output logic              mode_chg
);
    logic fs_evt;
    logic take;
    logic pend_vld;
    logic pend_nonint;

    ilace_evt #(.LINE_W(LINE_W)) u_evt (
        .clk        (clk),
        .rst_n      (rst_n),
        .master_sel (master_sel),
        .line_idx   (line_idx),
        .vsync_n    (vsync_n),
        .fs_evt     (fs_evt)
    );

    ilace_pend u_pend (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_stb     (req_stb),
        .req_nonint  (req_nonint),
        .take        (take),
        .pend_vld    (pend_vld),
        .pend_nonint (pend_nonint)
    );

    ilace_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .fs_evt      (fs_evt),
        .master_sel  (master_sel),
        .field_en    (field_en),
        .pend_vld    (pend_vld),
        .pend_nonint (pend_nonint),
        .take        (take),
        .mode_nonint (mode_nonint),
        .field_o     (field_o),
        .sync_coinc  (sync_coinc),
        .mode_chg    (mode_chg)
    );

endmodule

// File: rtl/ilace_switch_chk.sv
module ilace_switch_chk (
    input logic clk,
    input logic rst_n,
    input logic master_sel,
    input logic field_en,
    input logic mode_nonint,
    input logic field_o,
    input logic sync_coinc,
    input logic mode_chg
);
    // R3
    offset_only_f2_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_coinc |-> (!mode_nonint && field_o));

    // R4
    field_held_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_nonint && !field_en) |-> !field_o);

    // R9
    chg_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_chg |=> !mode_chg);

    // R9
    chg_marks_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_chg |-> (mode_nonint != $past(mode_nonint)));

    // R9
    mode_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_chg |-> $stable(mode_nonint));

    // R10
    chg_starts_f1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_chg |-> !field_o);

    // R6
    master_leaves_f2_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_chg && mode_nonint && master_sel && $past(master_sel)) |-> $past(field_o));

endmodule

bind ilace_switch ilace_switch_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .master_sel  (master_sel),
    .field_en    (field_en),
    .mode_nonint (mode_nonint),
    .field_o     (field_o),
    .sync_coinc  (sync_coinc),
    .mode_chg    (mode_chg)
);

// File: tb/ilace_switch_bench.sv
module ilace_switch_bench;
    localparam int CLK_PERIOD = 10;
    localparam int LW         = 6;
    localparam int NVEC       = 28;

    // bits: [9] req_stb [8] req_nonint [7] master_sel [6] field_en
    //       [5] line zero (else line 5) [4] vsync_n
    //       [3] exp mode_nonint [2] exp field_o [1] exp sync_coinc [0] exp mode_chg
    localparam logic [9:0] VEC [NVEC] = '{
        10'b0011010010, // 0  R1 idle after reset
        10'b0011110100, // 1  R2 wrap: F1 to F2
        10'b1111010100, // 2  R8 request progressive
        10'b0011111011, // 3  R6 applied from F2
        10'b0011011010, // 4  R9 pulse drops
        10'b0011111110, // 5  R4 parity odd shown
        10'b0010011010, // 6  R4 enable off holds low
        10'b0010111010, // 7  R4 back to even
        10'b1011011010, // 8  R6 request interlaced
        10'b0011110011, // 9  R10 applied, field 1
        10'b1111010010, // 10 R6 request progressive in F1
        10'b0011110100, // 11 R6 blocked from F1
        10'b1011010100, // 12 R8 replace with interlaced
        10'b0011110010, // 13 R8 consumed, no change
        10'b0011010010, // 14 R2 hold
        10'b0011110100, // 15 R3 field 2 offset
        10'b0001010100, // 16 R5 slave, no event
        10'b0001110100, // 17 R5 wrap ignored in slave
        10'b0001100010, // 18 R7 fall: F2 to F1
        10'b1101110010, // 19 R7 request progressive
        10'b0001101011, // 20 R7 applied from F1 in slave
        10'b0001111010, // 21 R9 pulse drops
        10'b1001101110, // 22 R7 request on fall waits
        10'b0001111110, // 23 R7 hold
        10'b0001100011, // 24 R7 applied on next fall
        10'b0001110010, // 25 R9 pulse drops
        10'b0001100100, // 26 R5 fall: F1 to F2
        10'b0001100100  // 27 R5 held low, no event
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_stb = 1'b0;
    logic          req_nonint = 1'b0;
    logic          master_sel = 1'b1;
    logic          field_en = 1'b1;
    logic [LW-1:0] line_idx = LW'(5);
    logic          vsync_n = 1'b1;
    logic          mode_nonint;
    logic          field_o;
    logic          sync_coinc;
    logic          mode_chg;

    int applied = 0;
    int bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ilace_switch #(.LINE_W(LW)) u_ilace_switch (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_stb     (req_stb),
        .req_nonint  (req_nonint),
        .master_sel  (master_sel),
        .field_en    (field_en),
        .line_idx    (line_idx),
        .vsync_n     (vsync_n),
        .mode_nonint (mode_nonint),
        .field_o     (field_o),
        .sync_coinc  (sync_coinc),
        .mode_chg    (mode_chg)
    );

    function automatic string tag_of(int i);
        case (i)
            0:                  return "R1";
            1, 14:              return "R2";
            15:                 return "R3";
            5, 6, 7:            return "R4";
            16, 17, 26, 27:     return "R5";
            3, 8, 10, 11:       return "R6";
            18, 19, 20, 22, 23, 24: return "R7";
            2, 12, 13:          return "R8";
            9:                  return "R10";
            default:            return "R9";
        endcase
    endfunction

    task automatic check(input logic [3:0] exp, input string tag);
        logic [3:0] act;
        act = {mode_nonint, field_o, sync_coinc, mode_chg};
        applied++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: {mode,field,coinc,chg} actual %b expected %b", tag, act, exp);
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL R1 watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
            $finish;
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        check(4'b0010, "R1");          // during reset
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            req_stb    = VEC[i][9];
            req_nonint = VEC[i][8];
            master_sel = VEC[i][7];
            field_en   = VEC[i][6];
            line_idx   = VEC[i][5] ? LW'(0) : LW'(5);
            vsync_n    = VEC[i][4];
            @(negedge clk);
            check(VEC[i][3:0], tag_of(i));
        end

        // R1: reset discards a pending request
        req_stb = 1'b1; req_nonint = 1'b1; vsync_n = 1'b1;
        @(negedge clk);
        req_stb = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        check(4'b0010, "R1");
        rst_n = 1'b1;
        @(negedge clk);
        vsync_n = 1'b0;                 // slave fall after reset
        @(negedge clk);
        check(4'b0100, "R1");           // only toggles to F2, no change

        // R5: master wrap with line staying zero makes one event only
        master_sel = 1'b1; vsync_n = 1'b1; line_idx = LW'(3);
        @(negedge clk);
        line_idx = LW'(0);
        @(negedge clk);
        check(4'b0010, "R5");
        @(negedge clk);
        check(4'b0010, "R5");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
        $finish;
    end

endmodule